// File: doc/BRIEF.md
# Blocked 3D Array Address Generator

This unit turns a packed 64-bit coordinate word into a byte offset within a 3D array that is stored in blocked order, so that voxels close together in space also sit close together in memory. The coordinate word carries three fixed-point values. Each x, y and z value has a fraction below a fixed integer start bit. The unit takes the low integer bits of the three axes and interleaves them into a fixed 17-bit block index. Above that index it stacks a number of further x bits, then the same number of further y bits, then four more z bits. How many x and y bits it keeps is set by a size exponent N.

An operation code chooses the element width: 8, 16 or 32 bits. The offset is scaled to match. An unsupported exponent or code raises an error flag and gives a zero offset. One request is accepted through a valid/ready handshake. The result appears in a register one cycle later. The unit takes no new request in that cycle, and it is ready again the cycle after.

Top module: `blk3d_addr_gen`

## Requirements
- R1: Offset bits [1:0] equal coordinate bits [12:11], bits [3:2] equal coordinate bits [34:33], and bit 4 equals coordinate bit 55, before element scaling.
- R2: Offset bits [8:5] equal coordinate bits [16:13], bits [12:9] equal coordinate bits [38:35], and bits [16:13] equal coordinate bits [59:56], before element scaling.
- R3: For exponent N, offset bits [17+N-1:17] equal coordinate bits [17+N-1:17], and offset bits [17+2N-1:17+N] equal coordinate bits [39+N-1:39], before scaling. When N is 0 these fields are empty.
- R4: Coordinate bits [63:60] land at offset bits [17+2N+3:17+2N], before scaling.
- R5: Coordinate bits [10:0], [32:22] and [54:44] never affect the result. For N below its maximum, x and y bits above the kept ones also have no effect.
- R6: Opcode 0x010 selects 8-bit elements and leaves the offset unshifted. Opcode 0x012 selects 16-bit elements and shifts it left by 1. Opcode 0x014 selects 32-bit elements and shifts it left by 2.
- R7: An exponent above 5 sets the error flag and forces the offset to zero.
- R8: Any opcode other than the three in R6 sets the error flag and forces the offset to zero.
- R9: Offset bits above the highest placed field, after scaling, are zero.
- R10: A request accepted at a clock edge (in_valid and in_ready both high) gives out_valid high for exactly the next cycle. in_ready is low during that cycle and high in the cycle after.
- R11: A request offered while in_ready is low is not taken. The result and error registers keep their values, and out_valid stays low in the following cycle.
- R12: After reset, out_valid, out_err and out_addr are zero and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_coord | input | 64 | Packed x, y, z fixed-point coordinates |
| in_exp | input | 3 | Size exponent N |
| in_opc | input | 9 | Element-size operation code |
| out_valid | output | 1 | Result register updated in the previous edge |
| out_addr | output | 64 | Scaled blocked byte offset |
| out_err | output | 1 | Exponent or opcode not supported |

## Verification
The assertions assume that in_valid is meaningful only when in_ready is high. They also assume the exponent is treated as an unsigned 3-bit value, so 6 and 7 are the only out-of-range codes. The stimulus mostly draws exponents from 0 to 5 and one of the three legal opcodes. It deliberately mixes in exponents 6 and 7 and arbitrary opcodes. Directed cases then cover the fraction-only word, the all-ones word at N=0 and N=5, and a request held across the busy cycle.

// File: rtl/blk3d_pkg.sv
// Shared constants and types for the blocked 3D address generator.
// Assumes a 64-bit coordinate word with fixed integer start bits per axis.
package blk3d_pkg;

    localparam int COORD_W = 64;
    localparam int ADDR_W  = 64;
    localparam int OPC_W   = 9;
    localparam int BASE_W  = 17;   // width of the fixed interleaved block index
    localparam int NIB_W   = 4;    // width of each nibble field
    localparam int ZTOP_W  = 4;    // z bits stacked above the upper x/y fields

    // integer start bits of each axis
    localparam int X_INT = 11;
    localparam int Y_INT = 33;
    localparam int Z_INT = 55;

    // first upper bit of each axis that lives above the block index
    localparam int X_UP   = X_INT + 6;   // 17
    localparam int Y_UP   = Y_INT + 6;   // 39
    localparam int Z_HIGH = Z_INT + 5;   // 60

    // element-size operation codes
    localparam logic [OPC_W-1:0] OPC_ESZ8  = 9'h010;
    localparam logic [OPC_W-1:0] OPC_ESZ16 = 9'h012;
    localparam logic [OPC_W-1:0] OPC_ESZ32 = 9'h014;

    typedef enum logic [1:0] {
        ESZ_BYTE = 2'd0,
        ESZ_HALF = 2'd1,
        ESZ_WORD = 2'd2,
        ESZ_NONE = 2'd3
    } esz_t;

endpackage

// File: rtl/blk3d_base_mix.sv
// Builds the fixed 17-bit interleaved block index from the low integer bits
// of x, y and z. Assumes the axis start bits given in blk3d_pkg; fraction
// bits are not read.
module blk3d_base_mix
    import blk3d_pkg::*;
(
    input  logic [COORD_W-1:0] coord,
    output logic [BASE_W-1:0]  base_idx
);

    // coordinate bits this slice does not read, reduced to one sink
    logic unused_coord;
    assign unused_coord = ^{coord[X_INT-1:0], coord[Y_INT-1:X_UP],
                            coord[Z_INT-1:Y_UP], coord[COORD_W-1:Z_HIGH]};

    // interleave: two x bits, two y bits, one z bit, then a nibble of each axis
    always_comb begin
        base_idx              = '0;
        base_idx[1:0]         = coord[X_INT +: 2];
        base_idx[3:2]         = coord[Y_INT +: 2];
        base_idx[4]           = coord[Z_INT];
        base_idx[5 +: NIB_W]  = coord[X_INT+2 +: NIB_W];
        base_idx[9 +: NIB_W]  = coord[Y_INT+2 +: NIB_W];
        base_idx[13 +: NIB_W] = coord[Z_INT+1 +: NIB_W];
    end

endmodule

// File: rtl/blk3d_upper_stack.sv
// Stacks the upper x, y and z bits above the block index. One candidate word
// is built per legal exponent value and the exponent picks among them.
// Assumes MAX_EXP keeps all fields inside their axis and inside the word.
module blk3d_upper_stack
    import blk3d_pkg::*;
#(
    parameter int MAX_EXP = 5,
    parameter int EXP_W   = 3
)(
    input  logic [COORD_W-1:0] coord,
    input  logic [EXP_W-1:0]   exp_n,
    output logic [ADDR_W-1:0]  upper,
    output logic               exp_ok
);

    localparam int NCAND = MAX_EXP + 1;

    logic [ADDR_W-1:0] cand [NCAND];

    // whole word is fed in; only some bits are read here
    logic unused_coord;
    assign unused_coord = ^coord;

    generate
        for (genvar n = 0; n < NCAND; n++) begin : g_cand
            // place n x bits, n y bits, then the z top nibble for exponent n
            always_comb begin
                cand[n] = '0;
                for (int i = 0; i < n; i++) begin
                    cand[n][BASE_W + i]     = coord[X_UP + i];
                    cand[n][BASE_W + n + i] = coord[Y_UP + i];
                end
                for (int j = 0; j < ZTOP_W; j++) begin
                    cand[n][BASE_W + 2*n + j] = coord[Z_HIGH + j];
                end
            end
        end
    endgenerate

    // select the candidate that matches the exponent; none when out of range
    always_comb begin
        upper  = '0;
        exp_ok = 1'b0;
        for (int k = 0; k < NCAND; k++) begin
            if (exp_n == EXP_W'(k)) begin
                upper  = cand[k];
                exp_ok = 1'b1;
            end
        end
    end

endmodule

// File: rtl/blk3d_scale.sv
// Decodes the element-size opcode, scales the raw offset and forms the error
// flag. Assumes the raw offset leaves two spare bits at the top of the word.
module blk3d_scale
    import blk3d_pkg::*;
(
    input  logic [OPC_W-1:0]  opc,
    input  logic              exp_ok,
    input  logic [ADDR_W-1:0] raw,
    output logic [ADDR_W-1:0] scaled,
    output logic              err
);

    esz_t esz;

    // map operation code to element size
    always_comb begin
        case (opc)
            OPC_ESZ8:  esz = ESZ_BYTE;
            OPC_ESZ16: esz = ESZ_HALF;
            OPC_ESZ32: esz = ESZ_WORD;
            default:   esz = ESZ_NONE;
        endcase
    end

    // shift by log2 of element bytes, zero the result on any error
    always_comb begin
        err = (esz == ESZ_NONE) || !exp_ok;
        case (esz)
            ESZ_BYTE: scaled = raw;
            ESZ_HALF: scaled = raw << 1;
            ESZ_WORD: scaled = raw << 2;
            default:  scaled = '0;
        endcase
        if (err) scaled = '0;
    end

endmodule

// File: rtl/blk3d_addr_gen.sv
// Top of the blocked 3D address generator: combines block index and upper
// fields, scales by element size and registers the result one cycle after a
// request is accepted. Assumes the requester drops or holds in_valid freely;
// no request is taken while a result is being presented.
module blk3d_addr_gen
    import blk3d_pkg::*;
#(
    parameter int MAX_EXP = 5,
    parameter int EXP_W   = 3
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [COORD_W-1:0] in_coord,
    input  logic [EXP_W-1:0]   in_exp,
    input  logic [OPC_W-1:0]   in_opc,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               out_err
);

    // highest bit that any legal field can reach after the widest scaling
    localparam int USED_W = BASE_W + 2*MAX_EXP + ZTOP_W + 2;

    logic [BASE_W-1:0] base_idx;
    logic [ADDR_W-1:0] upper;
    logic [ADDR_W-1:0] raw;
    logic [ADDR_W-1:0] scaled;
    logic              exp_ok;
    logic              err;
    logic              accept;

    blk3d_base_mix u_base (
        .coord    (in_coord),
        .base_idx (base_idx)
    );

    blk3d_upper_stack #(.MAX_EXP(MAX_EXP), .EXP_W(EXP_W)) u_upper (
        .coord  (in_coord),
        .exp_n  (in_exp),
        .upper  (upper),
        .exp_ok (exp_ok)
    );

    // merge the fixed block index under the stacked fields
    assign raw = upper | ADDR_W'(base_idx);

    blk3d_scale u_scale (
        .opc    (in_opc),
        .exp_ok (exp_ok),
        .raw    (raw),
        .scaled (scaled),
        .err    (err)
    );

    // ready whenever no result is being presented
    assign in_ready = !out_valid;
    assign accept   = in_valid && in_ready;

    // capture the result on accept, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_addr <= scaled;
                out_err  <= err;
            end
        end
    end

    // R10: an accepted request shows up on the next cycle
    a_r10_result_next: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

    // R10: a presented result lasts one cycle and the unit is ready after it
    a_r10_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (in_ready && !out_valid));

    // R7: out-of-range exponent gives error and zero offset
    a_r7_exp_err: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (in_exp > EXP_W'(MAX_EXP))) |=> (out_err && out_addr == '0));

    // R8: undefined opcode gives error and zero offset
    a_r8_opc_err: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_opc != OPC_ESZ8 && in_opc != OPC_ESZ16 && in_opc != OPC_ESZ32)
        |=> (out_err && out_addr == '0));

    // R9: nothing above the highest reachable field
    a_r9_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_addr[ADDR_W-1:USED_W] == '0));

    // R11: without an accept the result registers keep their values
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(out_addr) && $stable(out_err) && !out_valid));

endmodule

// File: tb/sim_blk3d_addr_gen.sv
`timescale 1ns/1ps
module sim_blk3d_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_coord = '0;
    logic [2:0]  in_exp = '0;
    logic [8:0]  in_opc = 9'h010;
    logic        out_valid;
    logic [63:0] out_addr;
    logic        out_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    blk3d_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_coord(in_coord), .in_exp(in_exp), .in_opc(in_opc),
        .out_valid(out_valid), .out_addr(out_addr), .out_err(out_err)
    );

    // expected {err, offset} built directly from the requirement text
    function automatic logic [64:0] model(input logic [63:0] c, input int n,
                                         input logic [8:0] op);
        logic [63:0] r = '0;
        int sh;
        if (op == 9'h010)      sh = 0;
        else if (op == 9'h012) sh = 1;
        else if (op == 9'h014) sh = 2;
        else                   return {1'b1, 64'd0};   // R8
        if (n > 5)             return {1'b1, 64'd0};   // R7
        r[1:0]   = c[12:11];
        r[3:2]   = c[34:33];
        r[4]     = c[55];
        r[8:5]   = c[16:13];
        r[12:9]  = c[38:35];
        r[16:13] = c[59:56];
        for (int i = 0; i < n; i++) begin
            r[17 + i]     = c[17 + i];
            r[17 + n + i] = c[39 + i];
        end
        for (int j = 0; j < 4; j++) r[17 + 2*n + j] = c[60 + j];
        return {1'b0, r << sh};
    endfunction

    task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one request: drive at negedge, check result one edge later, settle one more
    task automatic txn(input logic [63:0] c, input int n, input logic [8:0] op,
                       input string req);
        @(negedge clk);
        check("R10 ready before request", 65'(in_ready), 65'd1);
        in_valid = 1'b1;
        in_coord = c;
        in_exp   = 3'(n);
        in_opc   = op;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 valid after accept", 65'({out_valid, in_ready}), 65'b10);
        check(req, {out_err, out_addr}, model(c, n, op));
        @(negedge clk);
    endtask

    initial begin
        int seed_v;
        logic [63:0] c;
        logic [63:0] fracs;
        logic [64:0] first;
        int n;
        logic [8:0] op;
        seed_v = $urandom(32'd7351);

        repeat (3) @(negedge clk);
        // R12: reset values
        check("R12 reset outputs", {out_err, out_addr}, 65'd0);
        check("R12 reset handshake", 65'({out_valid, in_ready}), 65'b01);
        rst_n = 1'b1;

        // R1: low interleaved bits only
        txn(64'h0080_0006_0000_1800, 0, 9'h010, "R1 low bits");
        @(negedge clk);
        check("R1 low bits literal", {out_err, out_addr}, {1'b0, 64'h1F});
        // R2: nibble fields only
        txn(64'h0F00_0078_0001_E000, 2, 9'h010, "R2 nibbles");
        // R3: upper x and y at several exponents
        txn(64'h0000_0F80_003E_0000, 5, 9'h010, "R3 upper n5");
        txn(64'h0000_0A80_0014_0000, 3, 9'h010, "R3 upper n3");
        txn(64'h0000_0F80_003E_0000, 0, 9'h010, "R3 upper n0 drops");
        // R4: z top nibble position
        txn(64'hA000_0000_0000_0000, 0, 9'h010, "R4 ztop n0");
        txn(64'hA000_0000_0000_0000, 5, 9'h012, "R4 ztop n5");
        // R5: fraction and unused bits only
        fracs = 64'h007F_F001_FFC0_07FF;
        txn(fracs, 5, 9'h014, "R5 fraction ignored");
        @(negedge clk);
        check("R5 fraction literal", {out_err, out_addr}, 65'd0);
        // R6: three element sizes on the same coordinate
        c = 64'h5A5A_C3C3_9696_F0F0;
        txn(c, 4, 9'h010, "R6 byte");
        first = {out_err, out_addr};
        txn(c, 4, 9'h012, "R6 half");
        check("R6 half equals byte shl 1", {out_err, out_addr}, {1'b0, first[63:0] << 1});
        txn(c, 4, 9'h014, "R6 word");
        check("R6 word equals byte shl 2", {out_err, out_addr}, {1'b0, first[63:0] << 2});
        // R7: exponent out of range
        txn(64'hFFFF_FFFF_FFFF_FFFF, 6, 9'h010, "R7 exp6");
        txn(64'hFFFF_FFFF_FFFF_FFFF, 7, 9'h014, "R7 exp7");
        // R8: undefined opcodes
        txn(64'hFFFF_FFFF_FFFF_FFFF, 2, 9'h011, "R8 opc 011");
        txn(64'hFFFF_FFFF_FFFF_FFFF, 2, 9'h000, "R8 opc 000");
        // R9: all-ones word keeps the top zero
        txn(64'hFFFF_FFFF_FFFF_FFFF, 5, 9'h010, "R9 ones n5 byte");
        check("R9 ones n5 byte literal", {out_err, out_addr}, {1'b0, 64'h7FFF_FFFF});
        txn(64'hFFFF_FFFF_FFFF_FFFF, 5, 9'h014, "R9 ones n5 word");
        check("R9 ones n5 word literal", {out_err, out_addr}, {1'b0, 64'h1_FFFF_FFFC});
        txn(64'hFFFF_FFFF_FFFF_FFFF, 0, 9'h010, "R9 ones n0 byte");
        check("R9 ones n0 byte literal", {out_err, out_addr}, {1'b0, 64'h1F_FFFF});

        // R11: request held through the busy cycle with new data
        @(negedge clk);
        in_valid = 1'b1; in_coord = 64'h0080_0006_0000_1800; in_exp = 3'd0; in_opc = 9'h010;
        @(negedge clk);
        check("R11 first result", {out_err, out_addr}, {1'b0, 64'h1F});
        check("R10 busy not ready", 65'(in_ready), 65'd0);
        in_coord = 64'hFFFF_FFFF_FFFF_FFFF; in_exp = 3'd7;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 busy offer not taken", 65'(out_valid), 65'd0);
        check("R11 result held", {out_err, out_addr}, {1'b0, 64'h1F});
        check("R10 ready again", 65'(in_ready), 65'd1);

        // constrained random mix
        for (int t = 0; t < 400; t++) begin
            c = {$urandom, $urandom};
            n = ($urandom % 8 < 7) ? int'($urandom % 6) : 6 + int'($urandom % 2);
            case ($urandom % 10)
                0:       op = 9'($urandom);
                1, 2, 3: op = 9'h010;
                4, 5, 6: op = 9'h012;
                default: op = 9'h014;
            endcase
            txn(c, n, op, "R3 R4 R6 random");
            // R5: flipping unused bits leaves the result unchanged
            if (t % 8 == 0) txn(c ^ fracs, n, op, "R5 random fraction flip");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule